// File: doc/BRIEF.md
# Serial Audio Transmit Serializer

This block turns parallel audio samples into a serial bit stream on one or more data pins. It runs on the bit clock of a serial audio link. It follows the frame-sync signal in one of three framings: multi-slot TDM, I2S, or left-justified. New bits are launched on the falling bit-clock edge, so a receiver can capture them on the rising edge. Each data pin has three outputs: a data value, an output enable that drives the tri-state pad, and an enable for an external pad bus keeper.

The same static settings control every lane:
- a start delay of 0 to 31 bit clocks for the first word of each frame or half-frame;
- an option that releases the pin halfway through the last bit of each word;
- a four-way policy that sets when the pad keeper holds the line around that last bit.

Lane 0 is the primary pin and lane 1 the secondary pin. Both lanes share the same slot timing and carry their own sample words.

Top module: `audtx_serializer`

## Requirements
- R1: While `rstN` is low, every lane has `txOe` = 0 and `txData` = 0. `keeperEn` is 0 unless `cfgKeeper` = 1.
- R2: Each word is sent MSB first, one bit per bit clock, and the word's bits are taken from bit 31 downward. `cfgWordLen` selects the word length: 0 = 16 bits, 1 = 24 bits, 2 or 3 = 32 bits. Each bit is launched on a falling `bitClk` edge and stays valid until the next falling edge.
- R3: TDM framing is selected by `cfgFormat` = 0 or 3. A frame starts at a falling edge where `frameSync` is sampled high after being sampled low at the previous falling edge. With no start delay, the MSB of slot 0 is launched at that same edge. Slots 1 up to `NUM_SLOTS`-1 follow back to back, and slot k sends sample k.
- R4: `txOe` is 0 in every bit clock that is not a data bit of an enabled slot. A slot whose `slotEnable` bit is clear is never driven. `txData` is 0 whenever the pin is not driven.
- R5: I2S framing is selected by `cfgFormat` = 1. A falling `frameSync` starts the left word (sample 0, enable bit 0) and a rising `frameSync` starts the right word (sample 1, enable bit 1), with the MSB one bit clock after the transition. Left-justified framing is selected by `cfgFormat` = 2. A rising `frameSync` starts the left word and a falling one starts the right word, with no one-clock delay.
- R6: `cfgOffset` = N delays the first MSB of each frame (TDM) or of each half-frame (I2S and left-justified) by N further bit clocks. All later slots shift with it.
- R7: With `cfgLsbHalf` = 1, the pin is driven during the low half of each LSB bit clock and goes Hi-Z (`txOe` = 0) during its high half. With `cfgLsbHalf` = 0, the LSB is driven for the whole bit clock.
- R8: With `cfgKeeper` = 0, `keeperEn` is always 0. With `cfgKeeper` = 1, it is always 1.
- R9: With `cfgKeeper` = 2, `keeperEn` is 1 for exactly the whole bit clock of each transmitted LSB, and 0 at all other times.
- R10: With `cfgKeeper` = 3, `keeperEn` is 1 through each transmitted LSB bit clock and the low half of the next bit clock, and 0 at all other times.
- R11: All lanes have identical `txOe` and `keeperEn` timing. Each lane sends its own samples from `laneSamples`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bitClk | input | 1 | Serial bit clock; bits are launched on its falling edge |
| rstN | input | 1 | Asynchronous active-low reset |
| frameSync | input | 1 | Frame-sync level, sampled on falling edges |
| cfgFormat | input | 2 | Framing: 0/3 TDM, 1 I2S, 2 left-justified |
| cfgWordLen | input | 2 | Word length: 0=16, 1=24, 2/3=32 bits |
| cfgOffset | input | 5 | Extra start delay in bit clocks |
| cfgLsbHalf | input | 1 | 1 = release the pin in the second half of each LSB |
| cfgKeeper | input | 2 | Keeper policy: 0 off, 1 on, 2 LSB cycle, 3 LSB plus half cycle |
| slotEnable | input | NUM_SLOTS | Per-slot drive enable |
| laneSamples | input | NUM_LANES*NUM_SLOTS*32 | Sample words, indexed [lane][slot] |
| txData | output | NUM_LANES | Serial data per lane |
| txOe | output | NUM_LANES | Pad output enable per lane |
| keeperEn | output | NUM_LANES | Pad keeper enable per lane |

## Verification
Every framing is run with a random set of samples in each lane, in these configurations:
- TDM with all slots enabled and no delay, which shows that slot order and MSB placement are correct;
- TDM with a sparse enable mask, a short word and a small delay, which separates driven slots from undriven ones and shows that the whole frame shifts together;
- I2S and left-justified framing, which tell the two half-frame conventions apart and show the extra one-clock I2S delay;
- the largest delay, which exercises counter wrap and the end of each frame.

The LSB-release option and all four keeper policies are mixed across these runs. Both phases of the bit clock are compared, so a keeper window or Hi-Z window that lasts a half cycle too long or too short is caught.

// File: rtl/audtx_pkg.sv
package audtx_pkg;

  localparam int SAMPLE_W = 32;

  typedef enum logic [1:0] {
    FMT_TDM = 2'd0,
    FMT_I2S = 2'd1,
    FMT_LJ  = 2'd2
  } fmt_e;

  typedef enum logic [1:0] {
    KEEP_OFF     = 2'd0,
    KEEP_ON      = 2'd1,
    KEEP_LSB     = 2'd2,
    KEEP_LSB_EXT = 2'd3
  } keep_e;

  // Strobes from the control to each lane datapath.
  typedef struct packed {
    logic load;     // take a new word, emit its MSB
    logic shift;    // emit the next bit of the current word
    logic drive;    // this bit belongs to an enabled slot
    logic lsb;      // this bit is the last of its word
    logic postLsb;  // the previous bit was a driven LSB
  } strobe_t;

  function automatic fmt_e decodeFmt(input logic [1:0] code);
    case (code)
      2'd1:    return FMT_I2S;
      2'd2:    return FMT_LJ;
      default: return FMT_TDM;
    endcase
  endfunction

  function automatic logic [5:0] wordLast(input logic [1:0] code);
    case (code)
      2'd0:    return 6'd15;
      2'd1:    return 6'd23;
      default: return 6'd31;
    endcase
  endfunction

endpackage

// File: rtl/audtx_ctrl.sv
module audtx_ctrl
  import audtx_pkg::*;
#(
  parameter int NUM_SLOTS = 8
) (
  input  logic                         bitClk,
  input  logic                         rstN,
  input  logic                         frameSync,
  input  logic [1:0]                   cfgFormat,
  input  logic [1:0]                   cfgWordLen,
  input  logic [4:0]                   cfgOffset,
  input  logic [NUM_SLOTS-1:0]         slotEnable,
  output strobe_t                      nextStrb,
  output strobe_t                      strb,
  output logic [$clog2(NUM_SLOTS)-1:0] nextSlot
);

  localparam int SLOT_W = $clog2(NUM_SLOTS);
  localparam logic [SLOT_W-1:0] LAST_TDM_SLOT = SLOT_W'(NUM_SLOTS - 1);

  fmt_e              fmt;
  logic              fsPrev;
  logic              startEvt;
  logic              halfSel;
  logic [5:0]        startDelay;
  logic [5:0]        wlLast;
  logic [SLOT_W-1:0] startSlot;

  logic              waiting, waitingN;
  logic [5:0]        waitCnt, waitCntN;
  logic              running, runningN;
  logic [5:0]        bitIdx, bitIdxN;
  logic [SLOT_W-1:0] slotIdx, slotIdxN;
  logic [SLOT_W-1:0] lastSlot, lastSlotN;
  logic              loadN, shiftN;
  logic              enabledN;

  // Frame and half-frame start detection.
  always_comb begin
    fmt        = decodeFmt(cfgFormat);
    startEvt   = (fmt == FMT_TDM) ? (frameSync & ~fsPrev) : (frameSync ^ fsPrev);
    halfSel    = (fmt == FMT_I2S) ? frameSync : ~frameSync;
    startDelay = {1'b0, cfgOffset} + {5'd0, fmt == FMT_I2S};
    wlLast     = wordLast(cfgWordLen);
    startSlot  = (fmt == FMT_TDM) ? '0 : SLOT_W'(halfSel);
  end

  // Sequencer: wait out the start delay, then walk bits and slots.
  always_comb begin
    waitingN  = waiting;
    waitCntN  = waitCnt;
    runningN  = running;
    bitIdxN   = bitIdx;
    slotIdxN  = slotIdx;
    lastSlotN = lastSlot;
    loadN     = 1'b0;
    shiftN    = 1'b0;
    if (startEvt) begin
      slotIdxN  = startSlot;
      lastSlotN = (fmt == FMT_TDM) ? LAST_TDM_SLOT : startSlot;
      runningN  = 1'b0;
      bitIdxN   = '0;
      if (startDelay == 6'd0) begin
        waitingN = 1'b0;
        runningN = 1'b1;
        loadN    = 1'b1;
      end else begin
        waitingN = 1'b1;
        waitCntN = startDelay - 6'd1;
      end
    end else if (waiting) begin
      if (waitCnt == 6'd0) begin
        waitingN = 1'b0;
        runningN = 1'b1;
        bitIdxN  = '0;
        loadN    = 1'b1;
      end else begin
        waitCntN = waitCnt - 6'd1;
      end
    end else if (running) begin
      if (bitIdx == wlLast) begin
        if (slotIdx == lastSlot) begin
          runningN = 1'b0;
        end else begin
          slotIdxN = slotIdx + 1'b1;
          bitIdxN  = '0;
          loadN    = 1'b1;
        end
      end else begin
        bitIdxN = bitIdx + 6'd1;
        shiftN  = 1'b1;
      end
    end
  end

  always_comb begin
    enabledN         = runningN & slotEnable[slotIdxN];
    nextStrb.load    = loadN;
    nextStrb.shift   = shiftN;
    nextStrb.drive   = enabledN;
    nextStrb.lsb     = enabledN & (bitIdxN == wlLast);
    nextStrb.postLsb = strb.lsb;
    nextSlot         = slotIdxN;
  end

  always_ff @(negedge bitClk or negedge rstN) begin
    if (!rstN) begin
      fsPrev   <= 1'b0;
      waiting  <= 1'b0;
      waitCnt  <= '0;
      running  <= 1'b0;
      bitIdx   <= '0;
      slotIdx  <= '0;
      lastSlot <= '0;
      strb     <= '0;
    end else begin
      fsPrev   <= frameSync;
      waiting  <= waitingN;
      waitCnt  <= waitCntN;
      running  <= runningN;
      bitIdx   <= bitIdxN;
      slotIdx  <= slotIdxN;
      lastSlot <= lastSlotN;
      strb     <= nextStrb;
    end
  end

endmodule

// File: rtl/audtx_lane.sv
module audtx_lane
  import audtx_pkg::*;
#(
  parameter int NUM_SLOTS = 8
) (
  input  logic                                bitClk,
  input  logic                                rstN,
  input  strobe_t                             nextStrb,
  input  strobe_t                             strb,
  input  logic [$clog2(NUM_SLOTS)-1:0]        nextSlot,
  input  logic [NUM_SLOTS-1:0][SAMPLE_W-1:0]  samples,
  input  logic                                cfgLsbHalf,
  input  logic [1:0]                          cfgKeeper,
  output logic                                txData,
  output logic                                txOe,
  output logic                                keeperEn
);

  logic [SAMPLE_W-1:0] shiftReg;
  logic [SAMPLE_W-1:0] picked;
  logic                dataBit;
  logic                halfCut;

  assign picked = samples[nextSlot];

  // Shift register: launch one bit per falling edge.
  always_ff @(negedge bitClk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      dataBit  <= 1'b0;
    end else if (nextStrb.load) begin
      dataBit  <= nextStrb.drive & picked[SAMPLE_W-1];
      shiftReg <= picked << 1;
    end else if (nextStrb.shift) begin
      dataBit  <= nextStrb.drive & shiftReg[SAMPLE_W-1];
      shiftReg <= shiftReg << 1;
    end else begin
      dataBit  <= 1'b0;
    end
  end

  // Pin stage: half-cycle release and keeper window use the clock level.
  always_comb begin
    halfCut = cfgLsbHalf & strb.lsb & bitClk;
    txOe    = strb.drive & ~halfCut;
    txData  = dataBit;
    case (keep_e'(cfgKeeper))
      KEEP_OFF:     keeperEn = 1'b0;
      KEEP_ON:      keeperEn = 1'b1;
      KEEP_LSB:     keeperEn = strb.lsb;
      KEEP_LSB_EXT: keeperEn = strb.lsb | (strb.postLsb & ~bitClk);
      default:      keeperEn = 1'b0;
    endcase
  end

endmodule

// File: rtl/audtx_serializer.sv
module audtx_serializer
  import audtx_pkg::*;
#(
  parameter int NUM_LANES = 2,
  parameter int NUM_SLOTS = 8
) (
  input  logic                                               bitClk,
  input  logic                                               rstN,
  input  logic                                               frameSync,
  input  logic [1:0]                                         cfgFormat,
  input  logic [1:0]                                         cfgWordLen,
  input  logic [4:0]                                         cfgOffset,
  input  logic                                               cfgLsbHalf,
  input  logic [1:0]                                         cfgKeeper,
  input  logic [NUM_SLOTS-1:0]                               slotEnable,
  input  logic [NUM_LANES-1:0][NUM_SLOTS-1:0][SAMPLE_W-1:0]  laneSamples,
  output logic [NUM_LANES-1:0]                               txData,
  output logic [NUM_LANES-1:0]                               txOe,
  output logic [NUM_LANES-1:0]                               keeperEn
);

  localparam int SLOT_W = $clog2(NUM_SLOTS);

  strobe_t           ctrlNext;
  strobe_t           ctrlStrb;
  logic [SLOT_W-1:0] ctrlSlot;

  audtx_ctrl #(.NUM_SLOTS(NUM_SLOTS)) u_ctrl (
    .bitClk     (bitClk),
    .rstN       (rstN),
    .frameSync  (frameSync),
    .cfgFormat  (cfgFormat),
    .cfgWordLen (cfgWordLen),
    .cfgOffset  (cfgOffset),
    .slotEnable (slotEnable),
    .nextStrb   (ctrlNext),
    .strb       (ctrlStrb),
    .nextSlot   (ctrlSlot)
  );

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    audtx_lane #(.NUM_SLOTS(NUM_SLOTS)) u_lane (
      .bitClk     (bitClk),
      .rstN       (rstN),
      .nextStrb   (ctrlNext),
      .strb       (ctrlStrb),
      .nextSlot   (ctrlSlot),
      .samples    (laneSamples[g]),
      .cfgLsbHalf (cfgLsbHalf),
      .cfgKeeper  (cfgKeeper),
      .txData     (txData[g]),
      .txOe       (txOe[g]),
      .keeperEn   (keeperEn[g])
    );
  end

endmodule

// File: rtl/audtx_serializer_chk.sv
module audtx_serializer_chk
  import audtx_pkg::*;
#(
  parameter int NUM_LANES = 2
) (
  input logic                 bitClk,
  input logic                 rstN,
  input logic                 cfgLsbHalf,
  input logic [1:0]           cfgKeeper,
  input logic [NUM_LANES-1:0] txData,
  input logic [NUM_LANES-1:0] txOe,
  input logic [NUM_LANES-1:0] keeperEn,
  input strobe_t              ctrlStrb
);

  a_r8_keeper_off: assert property (@(negedge bitClk) disable iff (!rstN)
    (cfgKeeper == 2'd0) |-> (keeperEn == '0));

  a_r8_keeper_on: assert property (@(negedge bitClk) disable iff (!rstN)
    (cfgKeeper == 2'd1) |-> (keeperEn == '1));

  a_r9_keeper_lsb_only: assert property (@(negedge bitClk) disable iff (!rstN)
    (cfgKeeper == 2'd2 && !ctrlStrb.lsb) |-> (keeperEn == '0));

  a_r7_half_release: assert property (@(negedge bitClk) disable iff (!rstN)
    (cfgLsbHalf && ctrlStrb.lsb) |-> (txOe == '0));

  a_r4_idle_data_low: assert property (@(negedge bitClk) disable iff (!rstN)
    !ctrlStrb.drive |-> (txData == '0));

  a_r11_lanes_same_oe: assert property (@(negedge bitClk) disable iff (!rstN)
    (txOe == '0) || (txOe == '1));

endmodule

bind audtx_serializer audtx_serializer_chk #(.NUM_LANES(NUM_LANES)) u_chk (
  .bitClk     (bitClk),
  .rstN       (rstN),
  .cfgLsbHalf (cfgLsbHalf),
  .cfgKeeper  (cfgKeeper),
  .txData     (txData),
  .txOe       (txOe),
  .keeperEn   (keeperEn),
  .ctrlStrb   (ctrlStrb)
);

// File: tb/audtx_serializer_test.sv
module audtx_serializer_test;

  localparam int LANES = 2;
  localparam int SLOTS = 8;

  logic                              bitClk = 1'b0;
  logic                              rstN = 1'b0;
  logic                              frameSync = 1'b0;
  logic [1:0]                        cfgFormat = '0;
  logic [1:0]                        cfgWordLen = '0;
  logic [4:0]                        cfgOffset = '0;
  logic                              cfgLsbHalf = 1'b0;
  logic [1:0]                        cfgKeeper = '0;
  logic [SLOTS-1:0]                  slotEnable = '0;
  logic [LANES-1:0][SLOTS-1:0][31:0] laneSamples = '0;
  logic [LANES-1:0]                  txData, txOe, keeperEn;

  int    checks = 0;
  int    fails = 0;
  bit    done = 1'b0;
  string scen = "reset";

  // reference model state
  int         pos = 0;
  bit         fsM = 1'b0;
  bit         frameSeen = 1'b0;
  int         halfM = 0;
  bit         mDrive = 1'b0, mLsb = 1'b0, mPost = 1'b0;
  bit [LANES-1:0] mData = '0;

  audtx_serializer #(.NUM_LANES(LANES), .NUM_SLOTS(SLOTS)) uut (
    .bitClk(bitClk), .rstN(rstN), .frameSync(frameSync),
    .cfgFormat(cfgFormat), .cfgWordLen(cfgWordLen), .cfgOffset(cfgOffset),
    .cfgLsbHalf(cfgLsbHalf), .cfgKeeper(cfgKeeper), .slotEnable(slotEnable),
    .laneSamples(laneSamples), .txData(txData), .txOe(txOe), .keeperEn(keeperEn)
  );

  always #5 bitClk = ~bitClk;

  function automatic int wordBitsOf(input logic [1:0] c);
    return (c == 2'd0) ? 16 : (c == 2'd1) ? 24 : 32;
  endfunction

  // Behavioural model: bit position since the last frame event.
  always @(negedge bitClk) begin
    int rel, wl, nS, slot, bitn, base;
    bit isTdm, evt;
    if (!rstN) begin
      pos = 0; fsM = 1'b0; frameSeen = 1'b0;
      mDrive = 1'b0; mLsb = 1'b0; mPost = 1'b0; mData = '0;
    end else begin
      mPost = mLsb;
      isTdm = (cfgFormat != 2'd1) && (cfgFormat != 2'd2);
      evt = isTdm ? (frameSync && !fsM) : (frameSync != fsM);
      if (evt) begin
        pos = 0; frameSeen = 1'b1;
        halfM = (cfgFormat == 2'd1) ? int'(frameSync) : int'(!frameSync);
      end else begin
        pos++;
      end
      fsM = frameSync;
      base = int'(cfgOffset) + ((cfgFormat == 2'd1) ? 1 : 0);
      wl = wordBitsOf(cfgWordLen);
      nS = isTdm ? SLOTS : 1;
      rel = pos - base;
      mDrive = 1'b0; mLsb = 1'b0; mData = '0;
      if (frameSeen && rel >= 0 && rel < nS * wl) begin
        slot = isTdm ? rel / wl : halfM;
        bitn = rel % wl;
        if (slotEnable[slot]) begin
          mDrive = 1'b1;
          mLsb = (bitn == wl - 1);
          for (int l = 0; l < LANES; l++) mData[l] = laneSamples[l][slot][31-bitn];
        end
      end
    end
  end

  task automatic compare(input bit high);
    bit expOe, expK;
    string tD, tO, tK;
    for (int l = 0; l < LANES; l++) begin
      expOe = mDrive && !(high && cfgLsbHalf && mLsb);
      case (cfgKeeper)
        2'd0: expK = 1'b0;
        2'd1: expK = 1'b1;
        2'd2: expK = mLsb;
        default: expK = mLsb || (!high && mPost);
      endcase
      tD = (l == 0) ? "R2" : "R11";
      tO = (high && cfgLsbHalf && mLsb) ? "R7" : "R4";
      tK = (cfgKeeper < 2) ? "R8" : (cfgKeeper == 2) ? "R9" : "R10";
      checks += 3;
      if (txData[l] !== mData[l]) begin
        fails++;
        $display("FAIL %s [%s] lane %0d data t=%0t actual %0b expected %0b", tD, scen, l, $time, txData[l], mData[l]);
      end
      if (txOe[l] !== expOe) begin
        fails++;
        $display("FAIL %s [%s] lane %0d oe high=%0b t=%0t actual %0b expected %0b", tO, scen, l, high, $time, txOe[l], expOe);
      end
      if (keeperEn[l] !== expK) begin
        fails++;
        $display("FAIL %s [%s] lane %0d keeper high=%0b t=%0t actual %0b expected %0b", tK, scen, l, high, $time, keeperEn[l], expK);
      end
    end
  endtask

  // Compare in the middle of each clock phase.
  initial begin
    forever begin
      @(posedge bitClk); #2;
      if (rstN && !done) compare(1'b1);
      @(negedge bitClk); #2;
      if (rstN && !done) compare(1'b0);
    end
  end

  task automatic runCase(input string tag, input logic [1:0] fmt, input logic [1:0] wlc,
                         input logic [4:0] off, input bit half, input logic [1:0] keep,
                         input logic [SLOTS-1:0] mask, input int nFrames);
    int wl, len;
    @(posedge bitClk); #1;
    rstN = 1'b0;
    scen = tag;
    cfgFormat = fmt; cfgWordLen = wlc; cfgOffset = off;
    cfgLsbHalf = half; cfgKeeper = keep; slotEnable = mask;
    frameSync = (fmt == 2'd1);
    for (int l = 0; l < LANES; l++)
      for (int s = 0; s < SLOTS; s++) laneSamples[l][s] = $urandom;
    repeat (2) @(posedge bitClk);
    #2;
    // R1: outputs quiet in reset
    checks++;
    if (txOe !== '0 || txData !== '0 || keeperEn !== ((keep == 2'd1) ? '1 : '0)) begin
      fails++;
      $display("FAIL R1 [%s] reset outputs actual oe=%b data=%b keep=%b expected oe=0 data=0 keep=%0b",
               tag, txOe, txData, keeperEn, keep == 2'd1);
    end
    @(posedge bitClk); #1;
    rstN = 1'b1;
    wl = wordBitsOf(wlc);
    if (fmt == 2'd1 || fmt == 2'd2) begin
      len = wl + int'(off) + 3;
      for (int h = 0; h < 2 * nFrames; h++)
        for (int c = 0; c < len; c++) begin
          @(posedge bitClk); #1;
          if (c == 0 && h > 0) frameSync = ~frameSync;
        end
    end else begin
      len = SLOTS * wl + int'(off) + 3;
      for (int f = 0; f < nFrames; f++)
        for (int c = 0; c < len; c++) begin
          @(posedge bitClk); #1;
          frameSync = (c == 0);
        end
    end
    repeat (4) @(posedge bitClk);
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog [%s] actual timeout expected completion", scen);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    // R3 R2: TDM, full mask, no delay, 32-bit words, keeper off (R8)
    runCase("R3", 2'd0, 2'd2, 5'd0, 1'b0, 2'd0, 8'hFF, 3);
    // R6 R4 R7 R9: TDM sparse mask, 16-bit, delay 5, half LSB, keeper on LSB
    runCase("R6", 2'd0, 2'd0, 5'd5, 1'b1, 2'd2, 8'b1011_0101, 3);
    // R5: I2S 24-bit, keeper extended (R10)
    runCase("R5", 2'd1, 2'd1, 5'd0, 1'b0, 2'd3, 8'h03, 4);
    // R6 R8: I2S largest delay, keeper always on
    runCase("R6", 2'd1, 2'd0, 5'd31, 1'b0, 2'd1, 8'h03, 3);
    // R5 R4 R7 R10: left-justified, right word only, half LSB
    runCase("R5", 2'd2, 2'd2, 5'd2, 1'b1, 2'd3, 8'h02, 4);
    // R3 R6 R11: TDM code 3, 24-bit, max delay
    runCase("R11", 2'd3, 2'd1, 5'd31, 1'b0, 2'd2, 8'b0110_1001, 2);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule